// File: doc/BRIEF.md
# Packed Integer Vector ALU

This block is a 64-bit execution unit for packed integer arithmetic. Each operand is split at run time into eight 8-bit, four 16-bit or two 32-bit elements. The same operation is then applied to every element pair on its own. Carries never cross from one element into the next.

The unit supports addition and subtraction, each in wrapping or clamping form. It supports equality and signed greater-than tests that fill each element with a mask. It also has two 16-bit multiplies: one keeps the low half of each product and the other keeps the high half. A request that has no meaning, such as a multiply on 8-bit elements, returns zero and raises a flag.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream. There is a single output register between the two streams:
- An input is accepted when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result and flag are held unchanged and no new input is accepted.

Top module: `simd_alu`

## Requirements
- R1: `in_lane` picks the element width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = invalid. With `in_op` = 0 (add) and `in_sat` = 0, each element of the result is (a + b) mod 2^W, with no carry between elements. `in_uns` has no effect in this mode.
- R2: With `in_op` = 1 (subtract) and `in_sat` = 0, each element is (a − b) mod 2^W. `in_uns` has no effect in this mode.
- R3: With `in_sat` = 1 and `in_uns` = 0, add and subtract treat elements as two's complement. The exact result is clamped to [−2^(W−1), 2^(W−1)−1].
- R4: With `in_sat` = 1 and `in_uns` = 1, add and subtract treat elements as unsigned. The exact result is clamped to [0, 2^W−1].
- R5: With `in_op` = 2 (equality), each element is all ones when the two elements are equal and all zeros otherwise. `in_sat` and `in_uns` have no effect.
- R6: With `in_op` = 3 (greater-than), each element is all ones when the element of a is greater than the element of b as two's complement values, and all zeros otherwise. `in_sat` and `in_uns` have no effect.
- R7: With `in_op` = 4 (low multiply) and `in_lane` = 1, each 16-bit element is the low 16 bits of the product a×b.
- R8: With `in_op` = 5 (high multiply) and `in_lane` = 1, each 16-bit element is bits 31:16 of the signed 32-bit product a×b.
- R9: The request is illegal when `in_lane` = 3, when `in_op` is 6 or 7, or when `in_op` is 4 or 5 with `in_lane` ≠ 1. An illegal request gives `out_res` = 0 with `out_illegal` = 1; every legal request gives `out_illegal` = 0.
- R10: An accepted input shows up on the output in the next cycle with `out_valid` high. `in_ready` equals (!`out_valid` || `out_ready`). During a stall the output holds, and with no new input a drained output goes low.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| in_op | input | 3 | Operation code |
| in_lane | input | 2 | Element width select |
| in_sat | input | 1 | Clamp instead of wrap for add/subtract |
| in_uns | input | 1 | Unsigned clamp range |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_res | output | 64 | Packed result |
| out_illegal | output | 1 | Request was illegal |

## Verification
The bench sweeps every operation code, element width and mode bit over a set of edge operands, including 0x7F…/0x80… patterns, all ones, and 0x8000×0x8000.

Each corner case has a typical failure it would expose:
- A carry leaking across an element boundary corrupts the next element up.
- A clamp that uses the wrong range, or that ignores the sign of the overflow, gives the opposite extreme.
- A high multiply done unsigned gives wrong upper halves for negative elements.
- An unsigned greater-than flips the mask whenever the top bits differ.

A stall sequence checks that a result survives a held `out_ready` and is not overwritten by a pending input.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int VEC_W = 64;

  localparam logic [2:0] OPC_ADD   = 3'd0;
  localparam logic [2:0] OPC_SUB   = 3'd1;
  localparam logic [2:0] OPC_EQ    = 3'd2;
  localparam logic [2:0] OPC_GT    = 3'd3;
  localparam logic [2:0] OPC_MULLO = 3'd4;
  localparam logic [2:0] OPC_MULHI = 3'd5;

  localparam logic [1:0] LANE_8  = 2'd0;
  localparam logic [1:0] LANE_16 = 2'd1;
  localparam logic [1:0] LANE_32 = 2'd2;

  localparam int NUM_WIDTHS = 3;
  localparam int MUL_W = 16;

  typedef struct packed {
    logic [VEC_W-1:0] res;
    logic             illegal;
  } alu_out_t;
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sat,
  input  logic         uns,
  output logic [W-1:0] y
);
  logic [W:0] ext_a, ext_b, sum;
  logic       ovf;

  always_comb begin
    ext_a = uns ? {1'b0, a} : {a[W-1], a};
    ext_b = uns ? {1'b0, b} : {b[W-1], b};
    sum   = sub ? (ext_a - ext_b) : (ext_a + ext_b);
    ovf   = uns ? sum[W] : (sum[W] ^ sum[W-1]);
    if (!sat || !ovf) begin
      y = sum[W-1:0];
    end else if (uns) begin
      y = sub ? {W{1'b0}} : {W{1'b1}};
    end else begin
      y = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y_eq,
  output logic [W-1:0] y_gt
);
  always_comb begin
    y_eq = {W{a == b}};
    y_gt = {W{$signed(a) > $signed(b)}};
  end
endmodule

// File: rtl/simd_part.sv
module simd_part #(
  parameter int DW = 64,
  parameter int W  = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          sat,
  input  logic          uns,
  output logic [DW-1:0] y_as,
  output logic [DW-1:0] y_eq,
  output logic [DW-1:0] y_gt
);
  localparam int N = DW / W;

  for (genvar i = 0; i < N; i++) begin : g_lane
    simd_lane_addsub #(.W(W)) u_as (
      .a(a[i*W +: W]), .b(b[i*W +: W]),
      .sub(sub), .sat(sat), .uns(uns),
      .y(y_as[i*W +: W])
    );
    simd_lane_cmp #(.W(W)) u_cmp (
      .a(a[i*W +: W]), .b(b[i*W +: W]),
      .y_eq(y_eq[i*W +: W]), .y_gt(y_gt[i*W +: W])
    );
  end
endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
  parameter int DW = 64,
  parameter int MW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y_lo,
  output logic [DW-1:0] y_hi
);
  localparam int N = DW / MW;

  for (genvar i = 0; i < N; i++) begin : g_mul
    logic signed [2*MW-1:0] prod;
    always_comb begin
      prod = $signed(a[i*MW +: MW]) * $signed(b[i*MW +: MW]);
    end
    assign y_lo[i*MW +: MW] = prod[MW-1:0];
    assign y_hi[i*MW +: MW] = prod[2*MW-1:MW];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_lane,
  input  logic          in_sat,
  input  logic          in_uns,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_illegal
);
  logic [NUM_WIDTHS-1:0][DW-1:0] as_v, eq_v, gt_v;
  logic [DW-1:0] mul_lo, mul_hi;
  logic          is_mul, illegal;
  logic [DW-1:0] res_d;
  logic          valid_q;
  logic [DW-1:0] res_q;
  logic          ill_q;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int LW = 8 << g;
    simd_part #(.DW(DW), .W(LW)) u_part (
      .a(in_a), .b(in_b),
      .sub(in_op == OPC_SUB), .sat(in_sat), .uns(in_uns),
      .y_as(as_v[g]), .y_eq(eq_v[g]), .y_gt(gt_v[g])
    );
  end

  simd_mul #(.DW(DW), .MW(MUL_W)) u_mul (
    .a(in_a), .b(in_b), .y_lo(mul_lo), .y_hi(mul_hi)
  );

  always_comb begin
    is_mul  = (in_op == OPC_MULLO) || (in_op == OPC_MULHI);
    illegal = (in_lane > LANE_32) || (in_op > OPC_MULHI) ||
              (is_mul && (in_lane != LANE_16));
    res_d = '0;
    if (!illegal) begin
      unique case (in_op)
        OPC_ADD, OPC_SUB: res_d = as_v[in_lane];
        OPC_EQ:           res_d = eq_v[in_lane];
        OPC_GT:           res_d = gt_v[in_lane];
        OPC_MULLO:        res_d = mul_lo;
        OPC_MULHI:        res_d = mul_hi;
        default:          res_d = '0;
      endcase
    end
  end

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      ill_q   <= 1'b0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        ill_q <= illegal;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_res     = res_q;
  assign out_illegal = ill_q;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic [2:0]    in_op,
  input logic [1:0]    in_lane,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_res,
  input logic          out_illegal
);
  logic accept;
  logic byte_mask_ok;

  assign accept = in_valid && in_ready;

  always_comb begin
    byte_mask_ok = 1'b1;
    for (int i = 0; i < DW/8; i++) begin
      if (!(out_res[i*8 +: 8] == 8'h00 || out_res[i*8 +: 8] == 8'hFF))
        byte_mask_ok = 1'b0;
    end
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_illegal)); // R10
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R10
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_res == '0); // R9
  AST_MUL_BYTE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 3'd4 || in_op == 3'd5) && in_lane == 2'd0 |=> out_illegal); // R9
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 3'd2 && in_lane != 2'd3 && in_a == in_b |=> out_res == '1); // R5
  AST_GT_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 3'd3 && in_lane == 2'd0 |=> byte_mask_ok); // R6
endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/simd_alu_bench.sv
`timescale 1ns/1ps
module simd_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_lane = '0;
  logic        in_sat = 1'b0, in_uns = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_res;
  logic        out_illegal;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  simd_alu u_simd_alu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_lane(in_lane),
    .in_sat(in_sat), .in_uns(in_uns),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input logic [63:0] b, input int op,
                                input int lane, input bit sat, input bit uns,
                                output logic [63:0] r, output bit ill);
    int w, n;
    longint m, half, ua, ub, sa, sb, lr;
    ill = (lane == 3) || (op > 5) || ((op == 4 || op == 5) && lane != 1);
    r = '0;
    if (ill) return;
    w = 8 << lane;
    n = 64 / w;
    m = (64'sd1 <<< w) - 1;
    half = 64'sd1 <<< (w - 1);
    for (int i = 0; i < n; i++) begin
      ua = longint'((a >> (i*w)) & 64'(m));
      ub = longint'((b >> (i*w)) & 64'(m));
      sa = (ua >= half) ? ua - (m + 1) : ua;
      sb = (ub >= half) ? ub - (m + 1) : ub;
      lr = 0;
      case (op)
        0, 1: begin
          if (!sat) lr = (op == 0) ? ua + ub : ua - ub;
          else if (uns) begin
            lr = (op == 0) ? ua + ub : ua - ub;
            if (lr > m) lr = m;
            if (lr < 0) lr = 0;
          end else begin
            lr = (op == 0) ? sa + sb : sa - sb;
            if (lr > half - 1) lr = half - 1;
            if (lr < -half) lr = -half;
          end
        end
        2: lr = (ua == ub) ? m : 0;
        3: lr = (sa > sb) ? m : 0;
        4: lr = sa * sb;
        5: lr = (sa * sb) >>> 16;
        default: lr = 0;
      endcase
      r = r | (64'(lr & m) << (i*w));
    end
  endfunction

  function automatic string tag(input int op, input int lane, input bit sat, input bit uns);
    if ((lane == 3) || (op > 5) || ((op == 4 || op == 5) && lane != 1)) return "R9";
    case (op)
      0: return !sat ? "R1" : (uns ? "R4" : "R3");
      1: return !sat ? "R2" : (uns ? "R4" : "R3");
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [127:0] pattern(input int p);
    case (p)
      0: return {64'h0, 64'h0};
      1: return {64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101};
      2: return {64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101};
      3: return {64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080};
      4: return {64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000};
      5: return {64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001};
      6: return {64'h0000_0000_0000_0000, 64'h0000_0001_FFFF_0001};
      7: return {64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0};
      8: return {64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001};
      9: return {64'h7FFF_8001_FFFF_0002, 64'h7FFF_7FFF_FFFF_8000};
      default: return {$urandom, $urandom, $urandom, $urandom};
    endcase
  endfunction

  task automatic run_one(input logic [63:0] a, input logic [63:0] b, input int op,
                         input int lane, input bit sat, input bit uns);
    logic [63:0] er;
    bit          ei;
    string       t;
    in_a = a; in_b = b; in_op = 3'(op); in_lane = 2'(lane);
    in_sat = sat; in_uns = uns; in_valid = 1'b1;
    model(a, b, op, lane, sat, uns, er, ei);
    t = tag(op, lane, sat, uns);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", {64'h0, out_valid}, {64'h0, 1'b1});
    check(t, {out_res, out_illegal}, {er, ei});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [127:0] pv;
    logic [63:0]  er;
    bit           ei;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {63'h0, out_valid, in_ready}, {63'h0, 1'b0, 1'b1});

    for (int op = 0; op < 8; op++)
      for (int lane = 0; lane < 4; lane++)
        for (int s = 0; s < 2; s++)
          for (int u = 0; u < 2; u++)
            for (int p = 0; p < 24; p++) begin
              pv = pattern(p);
              run_one(pv[127:64], pv[63:0], op, lane, s[0], u[0]);
            end

    // R10 stall: result held while out_ready is low, pending input waits
    @(negedge clk);
    check("R10", {64'h0, out_valid}, {64'h0, 1'b0});
    out_ready = 1'b0;
    in_a = 64'h0102_0304_0506_0708; in_b = 64'h0101_0101_0101_0101;
    in_op = 3'd0; in_lane = 2'd0; in_sat = 1'b0; in_uns = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    model(64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101, 0, 0, 0, 0, er, ei);
    check("R10", {out_res, out_valid}, {er, 1'b1});
    check("R10", {64'h0, in_ready}, {64'h0, 1'b0});
    in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_op = 3'd1;
    @(negedge clk);
    @(negedge clk);
    check("R10", {out_res, out_valid}, {er, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1, 0, 0, 0, er, ei);
    check("R10", {out_res, out_valid}, {er, 1'b1});
    @(negedge clk);
    check("R10", {64'h0, out_valid}, {64'h0, 1'b0});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule